// File: doc/BRIEF.md
# ROM Signature Self-Test Controller

This block puts an embedded read-only memory, built as two physical halves, through an exhaustive self-test. When test mode is off, the memory address comes from the functional next-address logic. When test enable rises, the controller takes over the address. It starts from a value held in a loadable command register and visits every address, each one followed at once by its bitwise complement.

The word from each half is folded into its own 16-bit multiple-input signature register. While the signature registers compress, the bit leaving each register is visible on a single serial test pin. After the last pair, both final signatures are shifted out on the same pin and a done flag rises. Golden signatures are compared off-chip.

Top module: `rom_bist_ctrl`

## Requirements
- R1: A start address written through `cmd_addr_i` while `cmd_load_i` is high is held in a command register. The first address applied by a test pass equals that register's value at the moment test mode starts.
- R2: A pass applies 2^ADDR_W address/complement pairs. The base address counts up by one per pair, modulo 2^ADDR_W, from the start address, so every address appears as a base exactly once.
- R3: While the pass runs, applied addresses alternate: a base address in one cycle, then its bitwise complement in the next cycle.
- R4: Both signature registers are zero when test mode starts. On every applied address, each becomes next = (s << 1) ^ (s[15] ? 16'h1021 : 0) ^ data, where data is the word from its own half (A from `rom_data_a_i`, B from `rom_data_b_i`).
- R5: During compression, `test_so_o` shows bit 15 of register A in base-address cycles and bit 15 of register B in complement cycles. This is the value held before that cycle's update.
- R6: After the last pair, `test_so_o` carries register A and then register B, most significant bit first, one bit per clock (32 cycles). Then `done_o` rises and stays high with `test_so_o` low for as long as test enable stays high.
- R7: Outside a running pass, `rom_addr_o` equals `func_addr_i`. One clock after `test_en_i` goes low, the functional path is restored and `done_o` is low.
- R8: Dropping test enable part-way through a pass abandons it. Raising it again starts a new pass from zeroed signatures.
- R9: While `rst_ni` is low, `done_o` and `test_so_o` are low and `rom_addr_o` follows `func_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Test mode enable; rising starts a pass |
| cmd_load_i | input | 1 | Load strobe for the command register |
| cmd_addr_i | input | ADDR_W | Start address for the next pass |
| func_addr_i | input | ADDR_W | Functional next-address |
| rom_addr_o | output | ADDR_W | Address to the ROM |
| rom_data_a_i | input | 16 | Word from ROM half A |
| rom_data_b_i | input | 16 | Word from ROM half B |
| test_so_o | output | 1 | Serial test output |
| done_o | output | 1 | Pass complete |

## Verification
The bench starts passes at a mid-range address and at the top address, so the base counter must wrap. A counter that stopped at the top would skip addresses and give a wrong signature. It compares the serially unloaded signatures with signatures computed from the address order. This catches a wrong polynomial, a missed complement application, or A and B unloaded in the wrong order or least significant bit first. It also abandons a pass halfway and restarts. A design that kept stale signature state would then unload a signature different from a clean pass. Every cycle it checks that the address returns to the functional path one clock after test enable falls.

// File: rtl/rom_bist_pkg.sv
package rom_bist_pkg;
  localparam int unsigned SIG_W = 16;
  localparam logic [SIG_W-1:0] CCITT_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_UNLOAD,
    ST_DONE
  } bist_state_e;
endpackage

// File: rtl/rom_bist_misr.sv
module rom_bist_misr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    POLY = 16'h1021
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         comp_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sig_q;
  logic [W-1:0] fb;

  assign fb = sig_q[W-1] ? POLY : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= '0;
    else if (clear_i) sig_q <= '0;
    else if (comp_i)  sig_q <= {sig_q[W-2:0], 1'b0} ^ fb ^ data_i;
    else if (shift_i) sig_q <= {sig_q[W-2:0], 1'b0};
  end

  assign msb_o = sig_q[W-1];

  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sig_q == '0));

  assert_unload_msb_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !comp_i && !clear_i) |=> (msb_o == $past(sig_q[W-2])));
endmodule

// File: rtl/rom_bist_seq.sv
module rom_bist_seq
  import rom_bist_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned SIGW  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          test_en_i,
  input  logic [AW-1:0] start_addr_i,
  output bist_state_e   state_o,
  output logic          phase_o,
  output logic [AW-1:0] base_o,
  output logic          clear_o,
  output logic          comp_o,
  output logic          shift_a_o,
  output logic          shift_b_o,
  output logic          unload_b_o
);
  localparam int unsigned UW = $clog2(2 * SIGW);
  localparam logic [UW-1:0] U_LAST = UW'(2 * SIGW - 1);
  localparam logic [UW-1:0] U_HALF = UW'(SIGW);

  bist_state_e   state_q;
  logic          phase_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] pairs_q;
  logic [UW-1:0] ucnt_q;
  logic          last_pair;

  assign last_pair = &pairs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      base_q  <= '0;
      pairs_q <= '0;
      ucnt_q  <= '0;
    end else if (!test_en_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_RUN;
          base_q  <= start_addr_i;
          pairs_q <= '0;
          phase_q <= 1'b0;
        end
        ST_RUN: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            base_q  <= base_q + 1'b1;
            pairs_q <= pairs_q + 1'b1;
            if (last_pair) begin
              state_q <= ST_UNLOAD;
              ucnt_q  <= '0;
            end
          end
        end
        ST_UNLOAD: begin
          ucnt_q <= ucnt_q + 1'b1;
          if (ucnt_q == U_LAST) state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign phase_o    = phase_q;
  assign base_o     = base_q;
  assign clear_o    = test_en_i && (state_q == ST_IDLE);
  assign comp_o     = test_en_i && (state_q == ST_RUN);
  assign unload_b_o = (ucnt_q >= U_HALF);
  assign shift_a_o  = test_en_i && (state_q == ST_UNLOAD) && !unload_b_o;
  assign shift_b_o  = test_en_i && (state_q == ST_UNLOAD) && unload_b_o;

  assert_phase_alternates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && test_en_i) |=> (state_q != ST_RUN || phase_q != $past(phase_q)));

  assert_done_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && test_en_i) |=> (state_q == ST_DONE));

  assert_exit_on_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rom_bist_ctrl.sv
module rom_bist_ctrl
  import rom_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              cmd_load_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] func_addr_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [SIG_W-1:0]  rom_data_a_i,
  input  logic [SIG_W-1:0]  rom_data_b_i,
  output logic              test_so_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] cmd_q;
  bist_state_e       state;
  logic              phase;
  logic [ADDR_W-1:0] base;
  logic              clear, comp, shift_a, shift_b, unload_b;
  logic              msb_a, msb_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cmd_q <= '0;
    else if (cmd_load_i) cmd_q <= cmd_addr_i;
  end

  rom_bist_seq #(.AW(ADDR_W), .SIGW(SIG_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_en_i   (test_en_i),
    .start_addr_i(cmd_q),
    .state_o     (state),
    .phase_o     (phase),
    .base_o      (base),
    .clear_o     (clear),
    .comp_o      (comp),
    .shift_a_o   (shift_a),
    .shift_b_o   (shift_b),
    .unload_b_o  (unload_b)
  );

  rom_bist_misr #(.W(SIG_W), .POLY(CCITT_POLY)) u_misr_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .comp_i (comp),
    .shift_i(shift_a),
    .data_i (rom_data_a_i),
    .msb_o  (msb_a)
  );

  rom_bist_misr #(.W(SIG_W), .POLY(CCITT_POLY)) u_misr_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .comp_i (comp),
    .shift_i(shift_b),
    .data_i (rom_data_b_i),
    .msb_o  (msb_b)
  );

  always_comb begin
    rom_addr_o = func_addr_i;
    test_so_o  = 1'b0;
    unique case (state)
      ST_RUN: begin
        rom_addr_o = phase ? ~base : base;
        test_so_o  = phase ? msb_b : msb_a;
      end
      ST_UNLOAD: test_so_o = unload_b ? msb_b : msb_a;
      default: ;
    endcase
  end

  assign done_o = (state == ST_DONE);

  assert_func_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> (rom_addr_o == func_addr_i && !done_o));

  assert_complement_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp && !phase) |=> (state != ST_RUN || rom_addr_o == ~$past(rom_addr_o)));

  assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !test_so_o);
endmodule

// File: tb/rom_bist_ctrl_bench.sv
module rom_bist_ctrl_bench;
  localparam int AW = 6;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0, cmd_load = 1'b0;
  logic [AW-1:0] cmd_addr = '0, func_addr = '0;
  logic [AW-1:0] rom_addr;
  logic [15:0] rom_a, rom_b;
  logic test_so, done;

  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] rom_fn_a(input logic [AW-1:0] a);
    logic [15:0] x = {{(16-AW){1'b0}}, a};
    return (x * 16'd40503) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] rom_fn_b(input logic [AW-1:0] a);
    logic [15:0] x = {{(16-AW){1'b0}}, a};
    return {x[7:0], ~x[7:0]} + (x * 16'd977) ^ 16'h5A17;
  endfunction
  function automatic logic [15:0] crc_step(input logic [15:0] s, input logic [15:0] d);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ d;
  endfunction

  assign rom_a = rom_fn_a(rom_addr);
  assign rom_b = rom_fn_b(rom_addr);

  rom_bist_ctrl #(.ADDR_W(AW)) u_rom_bist_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(test_en), .cmd_load_i(cmd_load),
    .cmd_addr_i(cmd_addr), .func_addr_i(func_addr), .rom_addr_o(rom_addr),
    .rom_data_a_i(rom_a), .rom_data_b_i(rom_b), .test_so_o(test_so), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 run, 2 unload, 3 done
  int m_mode = 0, m_pairs = 0, m_u = 0;
  logic m_phase = 1'b0;
  logic [AW-1:0] m_cnt = '0, m_cmd = '0, m_start = '0;
  logic [15:0] m_sa = '0, m_sb = '0;
  logic [31:0] cap = '0;
  int seen[NADDR];

  task automatic cyc(input logic te, input logic ld, input logic [AW-1:0] cmd,
                     input logic [AW-1:0] fa);
    logic [AW-1:0] ea;
    logic es;
    @(negedge clk);
    test_en = te; cmd_load = ld; cmd_addr = cmd; func_addr = fa;
    #1;
    ea = (m_mode == 1) ? (m_phase ? ~m_cnt : m_cnt) : fa;
    es = 1'b0;
    if (m_mode == 1) es = m_phase ? m_sb[15] : m_sa[15];
    if (m_mode == 2) es = (m_u < 16) ? m_sa[15 - m_u] : m_sb[31 - m_u];
    if (m_mode == 1) begin
      chk("R3 run address", 32'(rom_addr), 32'(ea));
      chk("R5 quotient bit", 32'(test_so), 32'(es));
      if (m_pairs == 0 && !m_phase) chk("R1 first address", 32'(rom_addr), 32'(m_start));
      if (!m_phase) seen[m_cnt]++;
    end else begin
      chk("R7 functional address", 32'(rom_addr), 32'(ea));
      chk("R6 serial output", 32'(test_so), 32'(es));
    end
    chk("R6 done flag", 32'(done), 32'(m_mode == 3));
    if (m_mode == 2) cap[31 - m_u] = test_so;
    @(posedge clk);
    #1;
    if (!te) begin
      m_mode = 0; m_phase = 1'b0;
    end else begin
      case (m_mode)
        0: begin
          m_mode = 1; m_cnt = m_cmd; m_start = m_cmd; m_pairs = 0;
          m_phase = 1'b0; m_sa = '0; m_sb = '0;
          for (int i = 0; i < NADDR; i++) seen[i] = 0;
        end
        1: begin
          m_sa = crc_step(m_sa, rom_fn_a(ea));
          m_sb = crc_step(m_sb, rom_fn_b(ea));
          if (m_phase) begin
            m_cnt = m_cnt + 1'b1;
            m_pairs++;
            if (m_pairs == NADDR) begin m_mode = 2; m_u = 0; end
          end
          m_phase = ~m_phase;
        end
        2: begin
          m_u++;
          if (m_u == 32) m_mode = 3;
        end
        default: ;
      endcase
    end
    if (ld) m_cmd = cmd;
  endtask

  function automatic logic [31:0] golden(input logic [AW-1:0] start);
    logic [15:0] sa = '0, sb = '0;
    logic [AW-1:0] a;
    for (int i = 0; i < NADDR; i++) begin
      a = start + AW'(i);
      sa = crc_step(crc_step(sa, rom_fn_a(a)), rom_fn_a(~a));
      sb = crc_step(crc_step(sb, rom_fn_b(a)), rom_fn_b(~a));
    end
    return {sa, sb};
  endfunction

  task automatic full_pass(input logic [AW-1:0] start, input string tag);
    int guard = 0;
    int bad = 0;
    cyc(1'b0, 1'b1, start, AW'(3));
    cap = '0;
    cyc(1'b1, 1'b0, '0, AW'(9));
    while (m_mode != 3 && guard < 1000) begin
      cyc(1'b1, 1'b0, '0, AW'(guard));
      guard++;
    end
    chk({tag, " R4 unloaded signatures"}, cap, golden(start));
    for (int i = 0; i < NADDR; i++) if (seen[i] != 1) bad++;
    chk({tag, " R2 every base once"}, 32'(bad), 32'd0);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, '0, AW'(k * 5));
    chk({tag, " R6 done held"}, 32'(done), 32'd1);
    cyc(1'b0, 1'b0, '0, AW'(21));
    cyc(1'b0, 1'b0, '0, AW'(42));
    chk({tag, " R7 done dropped"}, 32'(done), 32'd0);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    func_addr = AW'(13);
    #23;
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R9 reset serial", 32'(test_so), 32'd0);
    chk("R9 reset address", 32'(rom_addr), 32'd13);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, '0, AW'(k * 11));
    full_pass(AW'(5), "start5");
    full_pass(AW'(NADDR - 1), "wrap");
    // R8: abandon mid-pass, then restart cleanly
    cyc(1'b0, 1'b1, AW'(58), AW'(1));
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, '0, AW'(k));
    cyc(1'b0, 1'b0, '0, AW'(7));
    chk("R8 abort returns address", 32'(rom_addr), 32'd7);
    full_pass(AW'(58), "R8 restart");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule